// File: doc/BRIEF.md
# I2C Line Timing Generator with Spike Filter

This block sits beneath an I2C master's bit engine. It turns one bit request into a full SCL clock pulse. It also places the SDA change inside the low phase, so that it respects a programmed hold delay after SCL falls and a programmed setup delay before SCL is released. Five timing values arrive as clock counts from configuration registers: SCL high period, SCL low period, SDA hold, SDA setup and spike-filter length. The low and high periods are independent of each other, so an asymmetric split such as one third high and two thirds low is a matter of configuration.

Both incoming lines pass through a deglitcher before any logic uses them. The high period is counted only once the filtered SCL is seen high. A target that holds SCL low therefore lengthens the cycle, and the block reports this as clock stretching. A small line-monitor register reads back the filtered line levels. Its override bits force either line low so that software can recover a stuck bus.

The sequencer has six states:
- LT_IDLE: both lines released.
- LT_HOLD: SCL is driven low and the block counts the hold delay.
- LT_SETUP: the new SDA value is driven and the block counts setup and low time.
- LT_RELEASE: SCL is released and the block waits for the filtered SCL to go high.
- LT_HIGH: the block counts the high period.
- LT_PARK: SCL is held low between bits.

The transitions are:
- A request moves LT_IDLE or LT_PARK to LT_HOLD.
- Hold met moves LT_HOLD to LT_SETUP.
- Setup and low met moves LT_SETUP to LT_RELEASE.
- Filtered SCL high moves LT_RELEASE to LT_HIGH.
- High met moves LT_HIGH to LT_IDLE when the bit was marked final, and to LT_PARK otherwise.

Top module: `i2c_line_timer`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, both filtered lines read 1, mon_rdata reads 4'b0011, and busy is 0.
- R2: A filtered line takes a new level only after the raw pin has shown that level on cfg_spike+1 consecutive clock edges. A shorter pulse leaves the filtered level unchanged.
- R3: With h = max(cfg_sda_hold,1), the hold count runs only while filtered SCL is low. From LT_IDLE, sda_chg_stb therefore rises cfg_spike+1+h cycles after scl_oe rises. From LT_PARK, with filtered SCL already low, it rises h cycles after the request is taken.
- R4: SDA, once changed, stays unchanged for at least max(cfg_sda_setup,1) cycles before scl_oe falls.
- R5: On a bit started from LT_IDLE, scl_oe stays 1 for max(cfg_scl_low, cfg_spike+1+h+max(cfg_sda_setup,1)) cycles.
- R6: After SCL is released, sample_stb pulses in the first cycle after filtered SCL is seen high. While the released SCL still reads low, stretch is 1. A target holding SCL low therefore delays sample_stb to cfg_spike+2 cycles after the target lets go.
- R7: bit_done pulses max(cfg_scl_high,1) cycles after sample_stb.
- R8: rd_bit holds the filtered SDA level as it was when sample_stb pulsed.
- R9: From sda_chg_stb onward, sda_oe equals the inverse of the requested bit value (1 drives SDA low). After a final bit (bit_last=1), sda_oe returns to 0 when bit_done pulses.
- R10: After a bit with bit_last=0, scl_oe stays 1 and busy stays 0 until the next request.
- R11: mon_rdata bit 0 is filtered SCL, bit 1 is filtered SDA, and bits 2 and 3 read back the override bits. Writing bit 2 set forces scl_oe to 1 from the next cycle, and writing bit 3 set forces sda_oe to 1.
- R12: bit_req while busy is 1 is ignored: no second bit follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_scl_high | input | CNT_W | SCL high period in clocks |
| cfg_scl_low | input | CNT_W | SCL low period in clocks |
| cfg_sda_setup | input | CNT_W | SDA setup before SCL release, clocks |
| cfg_sda_hold | input | CNT_W | SDA hold after SCL low, clocks |
| cfg_spike | input | FLT_W | Spike-filter length in clocks |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| bit_req | input | 1 | Request one bit cycle |
| bit_val | input | 1 | Bit value to place on SDA (1 = release) |
| bit_last | input | 1 | Leave SCL released after this bit |
| mon_wr | input | 1 | Write strobe for the line-monitor register |
| mon_wdata | input | 4 | Line-monitor write data (bits 2,3 used) |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |
| scl_filt | output | 1 | Deglitched SCL level |
| sda_filt | output | 1 | Deglitched SDA level |
| busy | output | 1 | A bit cycle is in progress |
| sda_chg_stb | output | 1 | SDA takes its new value this cycle |
| sample_stb | output | 1 | SDA sample point |
| rd_bit | output | 1 | SDA level taken at the sample point |
| bit_done | output | 1 | High period finished |
| stretch | output | 1 | SCL released but still seen low |
| mon_rdata | output | 4 | Line-monitor readback |

## Verification
The bench builds the block with CNT_W=8 and FLT_W=4. These widths keep every period within a few dozen cycles, so each bit can be measured edge by edge from the ports. The table sets cfg_spike anywhere from 0 to 3 and includes zero hold, setup, low and high values. The 0 setting shows the filter passing a single-cycle pulse, and the zero values exercise the minimum of one cycle per phase. Each row also mixes cases where the low period is set by the low count with cases where it is set by the hold and setup counts, which exercises both sides of the maximum in R5.

// File: rtl/i2c_lt_pkg.sv
package i2c_lt_pkg;

    typedef enum logic [2:0] {
        LT_IDLE,
        LT_HOLD,
        LT_SETUP,
        LT_RELEASE,
        LT_HIGH,
        LT_PARK
    } lt_state_e;

    localparam int MON_W     = 4;
    localparam int MON_SCL   = 0;
    localparam int MON_SDA   = 1;
    localparam int MON_FSCL  = 2;
    localparam int MON_FSDA  = 3;
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

endpackage

// File: rtl/i2c_lt_deglitch.sv
module i2c_lt_deglitch #(
    parameter int   FLT_W   = 6,
    parameter logic RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [FLT_W-1:0] len,
    output logic             filt
);
    // Counts consecutive edges on which the raw level differs from filt.
    logic [FLT_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= RST_LVL;
            run  <= '0;
        end else if (raw == filt) begin
            run <= '0;
        end else if (run >= len) begin
            filt <= raw;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_lt_busmon.sv
module i2c_lt_busmon
    import i2c_lt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [MON_W-1:0] wdata,
    input  logic             scl_f,
    input  logic             sda_f,
    output logic             ovr_scl,
    output logic             ovr_sda,
    output logic [MON_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_scl <= 1'b0;
            ovr_sda <= 1'b0;
        end else if (wr) begin
            ovr_scl <= wdata[MON_FSCL];
            ovr_sda <= wdata[MON_FSDA];
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[MON_SCL]  = scl_f;
        rdata[MON_SDA]  = sda_f;
        rdata[MON_FSCL] = ovr_scl;
        rdata[MON_FSDA] = ovr_sda;
    end
endmodule

// File: rtl/i2c_lt_seq.sv
module i2c_lt_seq
    import i2c_lt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             bit_last,
    output logic             scl_drv,
    output logic             sda_drv,
    output logic             busy,
    output logic             chg_stb,
    output logic             smp_stb,
    output logic             rd_bit,
    output logic             done,
    output logic             stretch
);
    localparam int EXT_W = CNT_W + 1;

    lt_state_e        st, st_nx;
    logic [CNT_W-1:0] cnt_ph;
    logic [CNT_W-1:0] cnt_low;
    logic             bv_q, bl_q;
    logic [EXT_W-1:0] ph_p1, low_p1;
    logic             hold_met, setup_met, high_met, accept;

    assign ph_p1     = {1'b0, cnt_ph} + 1'b1;
    assign low_p1    = {1'b0, cnt_low} + 1'b1;
    assign hold_met  = !scl_f && (ph_p1 >= {1'b0, cfg_hold});
    assign setup_met = (ph_p1 >= {1'b0, cfg_setup}) && (low_p1 >= {1'b0, cfg_low});
    assign high_met  = ph_p1 >= {1'b0, cfg_high};
    assign accept    = bit_req && (st == LT_IDLE || st == LT_PARK);

    // Next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            LT_IDLE:    if (bit_req)   st_nx = LT_HOLD;
            LT_PARK:    if (bit_req)   st_nx = LT_HOLD;
            LT_HOLD:    if (hold_met)  st_nx = LT_SETUP;
            LT_SETUP:   if (setup_met) st_nx = LT_RELEASE;
            LT_RELEASE: if (scl_f)     st_nx = LT_HIGH;
            LT_HIGH:    if (high_met)  st_nx = bl_q ? LT_IDLE : LT_PARK;
            default:                   st_nx = LT_IDLE;
        endcase
    end

    // State register, phase counters and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= LT_IDLE;
            cnt_ph  <= '0;
            cnt_low <= '0;
            bv_q    <= 1'b1;
            bl_q    <= 1'b1;
        end else begin
            st <= st_nx;
            if (st_nx != st)
                cnt_ph <= '0;
            else if (st == LT_HOLD && scl_f)
                cnt_ph <= cnt_ph;
            else if (cnt_ph != {CNT_W{1'b1}})
                cnt_ph <= cnt_ph + 1'b1;

            if (st_nx == LT_HOLD && st != LT_HOLD)
                cnt_low <= '0;
            else if ((st == LT_HOLD || st == LT_SETUP) && cnt_low != {CNT_W{1'b1}})
                cnt_low <= cnt_low + 1'b1;

            if (accept) begin
                bv_q <= bit_val;
                bl_q <= bit_last;
            end
        end
    end

    // Registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_drv <= 1'b0;
            sda_drv <= 1'b0;
            busy    <= 1'b0;
            chg_stb <= 1'b0;
            smp_stb <= 1'b0;
            rd_bit  <= 1'b1;
            done    <= 1'b0;
            stretch <= 1'b0;
        end else begin
            scl_drv <= (st_nx == LT_HOLD) || (st_nx == LT_SETUP) || (st_nx == LT_PARK);
            busy    <= !((st_nx == LT_IDLE) || (st_nx == LT_PARK));
            chg_stb <= (st == LT_HOLD) && (st_nx == LT_SETUP);
            smp_stb <= (st == LT_RELEASE) && (st_nx == LT_HIGH);
            done    <= (st == LT_HIGH) && (st_nx != LT_HIGH);
            stretch <= (st_nx == LT_RELEASE);
            if (st_nx == LT_IDLE)
                sda_drv <= 1'b0;
            else if (st == LT_HOLD && st_nx == LT_SETUP)
                sda_drv <= ~bv_q;
            if (st == LT_RELEASE && st_nx == LT_HIGH)
                rd_bit <= sda_f;
        end
    end
endmodule

// File: rtl/i2c_line_timer.sv
module i2c_line_timer
    import i2c_lt_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int FLT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_scl_high,
    input  logic [CNT_W-1:0] cfg_scl_low,
    input  logic [CNT_W-1:0] cfg_sda_setup,
    input  logic [CNT_W-1:0] cfg_sda_hold,
    input  logic [FLT_W-1:0] cfg_spike,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             bit_last,
    input  logic             mon_wr,
    input  logic [3:0]       mon_wdata,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             scl_filt,
    output logic             sda_filt,
    output logic             busy,
    output logic             sda_chg_stb,
    output logic             sample_stb,
    output logic             rd_bit,
    output logic             bit_done,
    output logic             stretch,
    output logic [3:0]       mon_rdata
);
    logic [NUM_LINES-1:0] raw_v, filt_v;
    logic                 scl_drv, sda_drv, ovr_scl, ovr_sda;

    assign raw_v[LINE_SCL] = scl_in;
    assign raw_v[LINE_SDA] = sda_in;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        i2c_lt_deglitch #(.FLT_W(FLT_W), .RST_LVL(1'b1)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[i]),
            .len  (cfg_spike),
            .filt (filt_v[i])
        );
    end

    assign scl_filt = filt_v[LINE_SCL];
    assign sda_filt = filt_v[LINE_SDA];

    i2c_lt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_high (cfg_scl_high),
        .cfg_low  (cfg_scl_low),
        .cfg_setup(cfg_sda_setup),
        .cfg_hold (cfg_sda_hold),
        .scl_f    (scl_filt),
        .sda_f    (sda_filt),
        .bit_req  (bit_req),
        .bit_val  (bit_val),
        .bit_last (bit_last),
        .scl_drv  (scl_drv),
        .sda_drv  (sda_drv),
        .busy     (busy),
        .chg_stb  (sda_chg_stb),
        .smp_stb  (sample_stb),
        .rd_bit   (rd_bit),
        .done     (bit_done),
        .stretch  (stretch)
    );

    i2c_lt_busmon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mon_wr),
        .wdata  (mon_wdata),
        .scl_f  (scl_filt),
        .sda_f  (sda_filt),
        .ovr_scl(ovr_scl),
        .ovr_sda(ovr_sda),
        .rdata  (mon_rdata)
    );

    assign scl_oe = scl_drv | ovr_scl;
    assign sda_oe = sda_drv | ovr_sda;
endmodule

// File: rtl/i2c_line_timer_chk.sv
module i2c_line_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_in,
    input logic       scl_filt,
    input logic       sda_filt,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       sda_chg_stb,
    input logic       sample_stb,
    input logic       bit_done,
    input logic       mon_wr,
    input logic [3:0] mon_wdata
);
    // R2
    scl_filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_filt) |-> scl_filt == $past(scl_in));
    // R2
    sda_filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_filt) |-> sda_filt == $past(sda_in));
    // R3
    chg_while_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg_stb |-> (!scl_filt && scl_oe));
    // R6
    sample_when_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_filt);
    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_chg_stb, sample_stb, bit_done}));
    // R11
    force_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_wr && mon_wdata[2]) |=> scl_oe);
    // R11
    force_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_wr && mon_wdata[3]) |=> sda_oe);
endmodule

bind i2c_line_timer i2c_line_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_filt   (scl_filt),
    .sda_filt   (sda_filt),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .sda_chg_stb(sda_chg_stb),
    .sample_stb (sample_stb),
    .bit_done   (bit_done),
    .mon_wr     (mon_wr),
    .mon_wdata  (mon_wdata)
);

// File: tb/i2c_line_timer_test.sv
module i2c_line_timer_test;
    localparam int CW = 8;
    localparam int FW = 4;
    localparam int NV = 6;
    // spike, hold, setup, low, high, val | chg, rel, smp, done
    localparam int VEC [NV][10] = '{
        '{0, 1, 1,  4, 3, 1,  2,  4,  6,  9},
        '{2, 3, 2,  5, 4, 0,  6,  8, 12, 16},
        '{1, 0, 0, 12, 6, 1,  3, 12, 15, 21},
        '{3, 2, 5,  6, 1, 0,  6, 11, 16, 17},
        '{0, 0, 0,  0, 0, 0,  2,  3,  5,  6},
        '{1, 4, 3, 20, 9, 1,  6, 20, 23, 32}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CW-1:0] c_high, c_low, c_setup, c_hold;
    logic [FW-1:0] c_spike;
    logic bit_req = 1'b0, bit_val = 1'b1, bit_last = 1'b1;
    logic mon_wr = 1'b0;
    logic [3:0] mon_wdata = 4'd0;
    logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic scl_in, sda_in, scl_oe, sda_oe, scl_filt, sda_filt, busy;
    logic sda_chg_stb, sample_stb, rd_bit, bit_done, stretch;
    logic [3:0] mon_rdata;
    int n_run = 0, n_fail = 0;
    int m_chg, m_rel, m_smp, m_done, m_oe_before;

    always #4 clk = ~clk;

    assign scl_in = ~(scl_oe | tb_scl_low);
    assign sda_in = ~(sda_oe | tb_sda_low);

    i2c_line_timer #(.CNT_W(CW), .FLT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_scl_high(c_high), .cfg_scl_low(c_low),
        .cfg_sda_setup(c_setup), .cfg_sda_hold(c_hold), .cfg_spike(c_spike),
        .scl_in(scl_in), .sda_in(sda_in),
        .bit_req(bit_req), .bit_val(bit_val), .bit_last(bit_last),
        .mon_wr(mon_wr), .mon_wdata(mon_wdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .busy(busy), .sda_chg_stb(sda_chg_stb), .sample_stb(sample_stb),
        .rd_bit(rd_bit), .bit_done(bit_done), .stretch(stretch), .mon_rdata(mon_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int h, input int su, input int lo, input int hi);
        c_spike = FW'(s); c_hold = CW'(h); c_setup = CW'(su);
        c_low = CW'(lo); c_high = CW'(hi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Issue one bit; record cycle indices of events (cycle 0 = first after acceptance).
    // extra_at >= 0 pulses bit_req again in that cycle (R12); rel_at >= 0 lets the
    // bench's target release SCL in that cycle.
    task automatic run_bit(input logic v, input logic last, input int extra_at, input int rel_at);
        m_chg = -1; m_rel = -1; m_smp = -1; m_done = -1; m_oe_before = -1;
        bit_val = v; bit_last = last; bit_req = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            bit_req = (k == extra_at);
            if (sda_chg_stb && m_chg < 0) m_chg = k;
            if (!scl_oe && m_rel < 0) begin
                m_rel = k;
            end else if (m_rel < 0) begin
                m_oe_before = int'(sda_oe);
            end
            if (sample_stb && m_smp < 0) m_smp = k;
            if (k == rel_at) begin
                check("R6 stretch flag while target holds SCL", int'(stretch), 1);
                tb_scl_low = 1'b0;
            end
            if (bit_done) begin
                m_done = k;
                break;
            end
        end
        bit_req = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        set_cfg(1, 1, 1, 4, 3);
        idle(3);
        // R1 reset state
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 mon_rdata", int'(mon_rdata), 3);
        check("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        idle(3);
        check("R1 filtered lines high", int'({scl_filt, sda_filt}), 3);

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            idle(8);
            run_bit(VEC[v][5] != 0, 1'b1, -1, -1);
            check("R3 hold before SDA change", m_chg, VEC[v][6]);
            check("R5 SCL low period", m_rel, VEC[v][7]);
            check("R4 setup before SCL release", int'((m_rel - m_chg) >= ((VEC[v][2] > 1) ? VEC[v][2] : 1)), 1);
            check("R9 SDA drive value", m_oe_before, (VEC[v][5] != 0) ? 0 : 1);
            check("R6 sample point", m_smp, VEC[v][8]);
            check("R7 high period", m_done, VEC[v][9]);
            check("R8 sampled bit", int'(rd_bit), VEC[v][5]);
            check("R9 SDA released after final bit", int'(sda_oe), 0);
        end

        // R10 park between bits, then R3 from park
        set_cfg(2, 2, 1, 3, 2);
        idle(8);
        run_bit(1'b1, 1'b0, -1, -1);
        check("R7 done of parked bit", m_done, 12);
        idle(6);
        check("R10 SCL held low in park", int'(scl_oe), 1);
        check("R10 not busy in park", int'(busy), 0);
        run_bit(1'b0, 1'b1, -1, -1);
        check("R3 hold from park", m_chg, 2);
        check("R5 low from park", m_rel, 3);
        check("R7 done from park", m_done, 9);

        // R6 clock stretching by target
        set_cfg(1, 1, 1, 4, 2);
        idle(8);
        tb_scl_low = 1'b1;
        run_bit(1'b1, 1'b1, -1, 10);
        check("R6 sample after stretch", m_smp, 13);
        check("R7 done after stretch", m_done, 15);

        // R12 request during a bit is ignored
        set_cfg(0, 1, 1, 4, 3);
        idle(8);
        run_bit(1'b1, 1'b1, 2, -1);
        check("R12 done unaffected", m_done, 9);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (scl_oe || busy) seen++;
            end
            check("R12 no second bit", seen, 0);
        end

        // R2 spike filter, length 3
        set_cfg(3, 1, 1, 4, 3);
        idle(8);
        tb_sda_low = 1'b1;
        begin
            int lowseen = 0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (!sda_filt) lowseen++;
            end
            tb_sda_low = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!sda_filt) lowseen++;
            end
            check("R2 short pulse rejected", lowseen, 0);
        end
        tb_sda_low = 1'b1;
        idle(3);
        check("R2 filter before length", int'(sda_filt), 1);
        @(negedge clk);
        check("R2 filter after length", int'(sda_filt), 0);
        tb_sda_low = 1'b0;
        idle(3);
        check("R2 filter held low", int'(sda_filt), 0);
        @(negedge clk);
        check("R2 filter returns high", int'(sda_filt), 1);
        set_cfg(0, 1, 1, 4, 3);
        idle(2);
        tb_scl_low = 1'b1;
        @(negedge clk);
        tb_scl_low = 1'b0;
        check("R2 zero length passes one cycle", int'(scl_filt), 0);
        @(negedge clk);
        check("R2 zero length recovers", int'(scl_filt), 1);

        // R11 line monitor
        set_cfg(1, 1, 1, 4, 3);
        idle(4);
        mon_wr = 1'b1; mon_wdata = 4'b0100;
        @(negedge clk);
        mon_wr = 1'b0;
        check("R11 force SCL", int'(scl_oe), 1);
        idle(4);
        check("R11 readback SCL forced", int'(mon_rdata), 4'b0110);
        mon_wr = 1'b1; mon_wdata = 4'b1000;
        @(negedge clk);
        mon_wr = 1'b0;
        check("R11 force SDA", int'({scl_oe, sda_oe}), 1);
        idle(4);
        check("R11 readback SDA forced", int'(mon_rdata), 4'b1001);
        mon_wr = 1'b1; mon_wdata = 4'b0000;
        @(negedge clk);
        mon_wr = 1'b0;
        idle(4);
        check("R11 readback released", int'(mon_rdata), 4'b0011);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule